// File: doc/BRIEF.md
# Load Miss Buffer

This block holds loads that have already cleared address translation and the permission check but did not find their line in the first-level data cache. Once a missing load has a slot here, the pipeline retires it with no data yet. Its destination register stays marked as pending in a small register scoreboard. Only later instructions that read that register are held back. Stores and all other independent work keep flowing.

Each slot runs its own state machine: `ST_FREE`, then `ST_ISSUE` (a line request must go to memory), then `ST_FILL` (waiting for the line), then `ST_DONE` (data captured, waiting for a writeback slot), then back to `ST_FREE`. The transitions are:
- `ST_FREE -> ST_ISSUE` on a plain allocation.
- `ST_FREE -> ST_FILL` when the allocation merges with a request already outstanding for the same line.
- `ST_FREE -> ST_DONE` when the line arrives in the very cycle of allocation.
- `ST_ISSUE -> ST_FILL` when memory accepts the request.
- `ST_ISSUE -> ST_DONE` or `ST_FILL -> ST_DONE` when the matching line returns.
- `ST_DONE -> ST_FREE` when the slot wins the writeback port.

When a line returns, the requested bytes are cut straight out of the incoming line for every slot waiting on it. The register writeback port is dedicated to this block, so it never competes with the pipeline's own writeback.

Top module: `load_miss_buffer`

## Requirements
- R1: Out of reset, all slots are free. `alloc_ready` is 1, while `wb_valid`, `mem_req_valid`, `q_busy1` and `q_busy2` are 0.
- R2: A load is taken when `alloc_valid` and `alloc_ready` are both 1 at a clock edge. From the next cycle, querying its destination register returns busy.
- R3: A slot that needs a request raises `mem_req_valid` with its line address from the cycle after allocation. The request stays up until a cycle with `mem_req_ready` high. When several slots wait to issue, the lowest-numbered slot goes first. Slots are always filled lowest free number first.
- R4: A load whose line already has a slot waiting to issue or waiting for data sends no second request to memory. It completes on the same returning line.
- R5: Returning data is captured for every waiting slot whose line matches. Size code 0, 1, 2 and 3 selects 1, 2, 4 and 8 bytes. The offset is a byte index into the line, where byte k occupies line bits 8k+7:8k. The byte at the offset lands in result bits 7:0, and the value is zero-extended. `wb_valid` rises in the cycle after the line arrives.
- R6: Only one writeback happens per cycle, and among completed slots the lowest-numbered one goes first. `wb_valid` is 0 when no slot is complete.
- R7: A register reads busy up to and including the cycle before its writeback. It reads not busy during the writeback cycle itself, so a dependent instruction can issue in the next cycle.
- R8: With all slots occupied, `alloc_ready` is 0 and a presented load is not taken. A slot freed by writeback can accept a new load from the cycle after that writeback.
- R9: `alloc_ready` is 0 while `alloc_rd` names a register that reads busy.
- R10: If a load is allocated in the same cycle that its line arrives, it sends no request and writes back in the next cycle.
- R11: A returning line that matches no waiting slot changes nothing: there is no writeback, and pending registers stay busy.
- R12: A register with no pending load reads not busy, even while other registers are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | A translated load missed the cache |
| alloc_ready | output | 1 | A slot is free and the destination is not pending |
| alloc_line | input | LINE_AW | Line address of the load |
| alloc_off | input | log2(LINE_BYTES) | Byte offset within the line |
| alloc_size | input | 2 | Size code (0: 1 B, 1: 2 B, 2: 4 B, 3: 8 B) |
| alloc_rd | input | log2(NUM_REGS) | Destination register |
| q_rs1 | input | log2(NUM_REGS) | First source register to look up |
| q_busy1 | output | 1 | First source is pending |
| q_rs2 | input | log2(NUM_REGS) | Second source register to look up |
| q_busy2 | output | 1 | Second source is pending |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_line | output | LINE_AW | Requested line address |
| refill_valid | input | 1 | A line is returning |
| refill_line | input | LINE_AW | Address of the returning line |
| refill_data | input | 8*LINE_BYTES | Returning line contents |
| wb_valid | output | 1 | Register writeback this cycle |
| wb_rd | output | log2(NUM_REGS) | Register being written |
| wb_data | output | XLEN | Zero-extended load result |

## Verification
If a slot is stuck in the wrong state, it shows within a cycle or two of the returning line. The result is a missing or doubled `wb_valid`, or a register that stays busy forever and would stall a dependent instruction without end. A lost merge shows up as a second `mem_req_valid` for an identical line, one cycle after the first request is accepted. A wrong offset or size shows up as a wrong `wb_data` in the writeback cycle. A scoreboard that clears one cycle late shows up as busy during the writeback cycle.

// File: rtl/lmb_pkg.sv
package lmb_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } ld_size_e;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FILL  = 2'd2,
        ST_DONE  = 2'd3
    } ent_state_e;

endpackage

// File: rtl/lmb_prio_pick.sv
module lmb_prio_pick #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // Lowest index wins: scan downward so the last hit kept is the lowest.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
                any    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lmb_entry.sv
module lmb_entry
    import lmb_pkg::*;
#(
    parameter int LINE_AW    = 26,
    parameter int LINE_BYTES = 16,
    parameter int XLEN       = 64,
    parameter int REG_W      = 5,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_en,
    input  logic [LINE_AW-1:0] alloc_line,
    input  logic [OFF_W-1:0]   alloc_off,
    input  logic [1:0]         alloc_size,
    input  logic [REG_W-1:0]   alloc_rd,
    input  logic               alloc_hit,
    input  logic               alloc_merge,
    input  logic               req_gnt,
    input  logic               wb_gnt,
    input  logic               fill_valid,
    input  logic [LINE_AW-1:0] fill_line,
    input  logic [LINE_W-1:0]  fill_data,
    output ent_state_e         state_o,
    output logic [LINE_AW-1:0] line_o,
    output logic [REG_W-1:0]   rd_o,
    output logic [XLEN-1:0]    data_o
);

    ent_state_e         state_q, state_d;
    logic [OFF_W-1:0]   off_q;
    ld_size_e           size_q;
    logic               fill_match;
    logic               take_data;
    logic               take_alloc;
    logic [OFF_W-1:0]   off_sel;
    ld_size_e           size_sel;
    logic [LINE_W-1:0]  shifted;
    logic [LINE_W-1:0]  lane_mask;
    logic [XLEN-1:0]    extracted;

    assign fill_match = fill_valid && (fill_line == line_o);
    assign take_alloc = (state_q == ST_FREE) && alloc_en;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (alloc_en) begin
                    if (alloc_hit)        state_d = ST_DONE;
                    else if (alloc_merge) state_d = ST_FILL;
                    else                  state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (fill_match)   state_d = ST_DONE;
                else if (req_gnt) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (fill_match) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (wb_gnt) state_d = ST_FREE;
            end
            default: state_d = ST_FREE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    // Capture paths: an allocation that meets its line in flight uses the
    // incoming offset and size; otherwise the stored ones.
    assign take_data = (take_alloc && alloc_hit)
                     || (((state_q == ST_ISSUE) || (state_q == ST_FILL)) && fill_match);
    assign off_sel   = take_alloc ? alloc_off : off_q;
    assign size_sel  = take_alloc ? ld_size_e'(alloc_size) : size_q;
    assign shifted   = fill_data >> {off_sel, 3'b000};

    always_comb begin
        unique case (size_sel)
            SZ_BYTE: lane_mask = LINE_W'(8'hFF);
            SZ_HALF: lane_mask = LINE_W'(16'hFFFF);
            SZ_WORD: lane_mask = LINE_W'(32'hFFFF_FFFF);
            default: lane_mask = LINE_W'(64'hFFFF_FFFF_FFFF_FFFF);
        endcase
        extracted = XLEN'(shifted & lane_mask);
    end

    // Payload registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_o <= '0;
            off_q  <= '0;
            size_q <= SZ_BYTE;
            rd_o   <= '0;
            data_o <= '0;
        end else begin
            if (take_alloc) begin
                line_o <= alloc_line;
                off_q  <= alloc_off;
                size_q <= ld_size_e'(alloc_size);
                rd_o   <= alloc_rd;
            end
            if (take_data) begin
                data_o <= extracted;
            end
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/load_miss_buffer.sv
module load_miss_buffer
    import lmb_pkg::*;
#(
    parameter int ENTRIES    = 4,
    parameter int LINE_AW    = 26,
    parameter int LINE_BYTES = 16,
    parameter int XLEN       = 64,
    parameter int NUM_REGS   = 32,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int REG_W     = $clog2(NUM_REGS),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid,
    output logic               alloc_ready,
    input  logic [LINE_AW-1:0] alloc_line,
    input  logic [OFF_W-1:0]   alloc_off,
    input  logic [1:0]         alloc_size,
    input  logic [REG_W-1:0]   alloc_rd,
    input  logic [REG_W-1:0]   q_rs1,
    output logic               q_busy1,
    input  logic [REG_W-1:0]   q_rs2,
    output logic               q_busy2,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [LINE_AW-1:0] mem_req_line,
    input  logic               refill_valid,
    input  logic [LINE_AW-1:0] refill_line,
    input  logic [LINE_W-1:0]  refill_data,
    output logic               wb_valid,
    output logic [REG_W-1:0]   wb_rd,
    output logic [XLEN-1:0]    wb_data
);

    ent_state_e         st       [ENTRIES];
    logic [LINE_AW-1:0] ent_line [ENTRIES];
    logic [REG_W-1:0]   ent_rd   [ENTRIES];
    logic [XLEN-1:0]    ent_data [ENTRIES];

    logic [ENTRIES-1:0] free_v, issue_v, done_v, pend_same, hold_v;
    logic [ENTRIES-1:0] q1_hit, q2_hit, rd_hit;
    logic [ENTRIES-1:0] alloc_gnt, req_gnt_v, wb_gnt;
    logic [IDX_W-1:0]   alloc_idx, req_idx, wb_idx;
    logic               free_any, req_any, wb_any;
    logic               alloc_fire, alloc_hit, alloc_merge, alloc_rd_busy;

    lmb_prio_pick #(.N(ENTRIES)) u_pick_alloc (
        .req(free_v), .gnt(alloc_gnt), .idx(alloc_idx), .any(free_any)
    );
    lmb_prio_pick #(.N(ENTRIES)) u_pick_req (
        .req(issue_v), .gnt(req_gnt_v), .idx(req_idx), .any(req_any)
    );
    lmb_prio_pick #(.N(ENTRIES)) u_pick_wb (
        .req(done_v), .gnt(wb_gnt), .idx(wb_idx), .any(wb_any)
    );

    assign alloc_hit     = refill_valid && (refill_line == alloc_line);
    assign alloc_merge   = |pend_same;
    assign alloc_rd_busy = |rd_hit;
    assign alloc_ready   = free_any && !alloc_rd_busy;
    assign alloc_fire    = alloc_valid && alloc_ready;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        lmb_entry #(
            .LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES), .XLEN(XLEN), .REG_W(REG_W)
        ) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_en   (alloc_fire && alloc_gnt[g]),
            .alloc_line (alloc_line),
            .alloc_off  (alloc_off),
            .alloc_size (alloc_size),
            .alloc_rd   (alloc_rd),
            .alloc_hit  (alloc_hit),
            .alloc_merge(alloc_merge),
            .req_gnt    (req_gnt_v[g] && mem_req_ready),
            .wb_gnt     (wb_gnt[g]),
            .fill_valid (refill_valid),
            .fill_line  (refill_line),
            .fill_data  (refill_data),
            .state_o    (st[g]),
            .line_o     (ent_line[g]),
            .rd_o       (ent_rd[g]),
            .data_o     (ent_data[g])
        );

        assign free_v[g]    = (st[g] == ST_FREE);
        assign issue_v[g]   = (st[g] == ST_ISSUE);
        assign done_v[g]    = (st[g] == ST_DONE);
        assign pend_same[g] = ((st[g] == ST_ISSUE) || (st[g] == ST_FILL))
                            && (ent_line[g] == alloc_line);
        // A slot stops claiming its register in the cycle it writes back.
        assign hold_v[g]    = (st[g] != ST_FREE) && !wb_gnt[g];
        assign q1_hit[g]    = hold_v[g] && (ent_rd[g] == q_rs1);
        assign q2_hit[g]    = hold_v[g] && (ent_rd[g] == q_rs2);
        assign rd_hit[g]    = hold_v[g] && (ent_rd[g] == alloc_rd);
    end

    assign q_busy1       = |q1_hit;
    assign q_busy2       = |q2_hit;

    assign mem_req_valid = req_any;
    assign mem_req_line  = ent_line[req_idx];

    assign wb_valid      = wb_any;
    assign wb_rd         = ent_rd[wb_idx];
    assign wb_data       = ent_data[wb_idx];

endmodule

// File: rtl/load_miss_buffer_chk.sv
module load_miss_buffer_chk #(
    parameter int ENTRIES  = 4,
    parameter int NUM_REGS = 32,
    localparam int REG_W   = $clog2(NUM_REGS),
    localparam int OCC_W   = $clog2(ENTRIES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic [REG_W-1:0] alloc_rd,
    input logic [REG_W-1:0] q_rs1,
    input logic             q_busy1,
    input logic             mem_req_valid,
    input logic             wb_valid,
    input logic [REG_W-1:0] wb_rd
);

    logic [OCC_W-1:0] occ;

    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else        occ <= OCC_W'(int'(occ) + int'(alloc_valid && alloc_ready) - int'(wb_valid));
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_W'(ENTRIES)) |-> !alloc_ready); // R8

    AST_WB_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (occ != '0)); // R6

    AST_REQ_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (occ != '0)); // R3

    AST_SB_CLEAR_ON_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && (q_rs1 == wb_rd)) |-> !q_busy1); // R7

    AST_PENDING_RD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (q_busy1 && (q_rs1 == alloc_rd)) |-> !alloc_ready); // R9

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> (!wb_valid && !mem_req_valid && alloc_ready)); // R1

endmodule

bind load_miss_buffer load_miss_buffer_chk #(
    .ENTRIES(ENTRIES), .NUM_REGS(NUM_REGS)
) u_chk (.*);

// File: tb/load_miss_buffer_test.sv
`timescale 1ns/1ps
module load_miss_buffer_test;

    localparam logic [127:0] PAT = 128'hCFCE_CDCC_CBCA_C9C8_C7C6_C5C4_C3C2_C1C0;
    localparam int NV = 7;
    localparam logic [25:0] V_LINE [NV] = '{26'h010, 26'h011, 26'h012, 26'h013, 26'h014, 26'h015, 26'h016};
    localparam logic [3:0]  V_OFF  [NV] = '{4'd3, 4'd6, 4'd8, 4'd8, 4'd0, 4'd15, 4'd14};
    localparam logic [1:0]  V_SZ   [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd0, 2'd1};
    localparam logic [4:0]  V_RD   [NV] = '{5'd1, 5'd7, 5'd12, 5'd31, 5'd0, 5'd18, 5'd25};
    localparam logic [63:0] V_EXP  [NV] = '{64'hC3, 64'hC7C6, 64'hCBCA_C9C8,
                                            64'hCFCE_CDCC_CBCA_C9C8, 64'hC7C6_C5C4_C3C2_C1C0,
                                            64'hCF, 64'hCFCE};

    logic         clk = 1'b0;
    logic         rst_n;
    logic         alloc_valid, alloc_ready;
    logic [25:0]  alloc_line;
    logic [3:0]   alloc_off;
    logic [1:0]   alloc_size;
    logic [4:0]   alloc_rd, q_rs1, q_rs2;
    logic         q_busy1, q_busy2;
    logic         mem_req_valid, mem_req_ready;
    logic [25:0]  mem_req_line;
    logic         refill_valid;
    logic [25:0]  refill_line;
    logic [127:0] refill_data;
    logic         wb_valid;
    logic [4:0]   wb_rd;
    logic [63:0]  wb_data;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    load_miss_buffer uut (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        alloc_valid = 1'b0; alloc_line = '0; alloc_off = '0; alloc_size = '0; alloc_rd = '0;
        q_rs1 = '0; q_rs2 = '0; mem_req_ready = 1'b0;
        refill_valid = 1'b0; refill_line = '0; refill_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        do_reset();
        #1;
        check("R1 alloc_ready", alloc_ready, 1);
        check("R1 wb_valid", wb_valid, 0);
        check("R1 mem_req_valid", mem_req_valid, 0);
        check("R1 q_busy1", q_busy1, 0);
        check("R1 q_busy2", q_busy2, 0);

        // Vector table: one load per entry through the full slot lifecycle.
        for (int i = 0; i < NV; i++) begin
            do_reset();
            cyc();
            alloc_valid = 1; alloc_line = V_LINE[i]; alloc_off = V_OFF[i];
            alloc_size = V_SZ[i]; alloc_rd = V_RD[i]; q_rs1 = V_RD[i];
            #1;
            check("R2 ready before take", alloc_ready, 1);
            check("R2 not busy before take", q_busy1, 0);
            cyc(); alloc_valid = 0; #1;
            check("R2 busy after take", q_busy1, 1);
            check("R3 request raised", mem_req_valid, 1);
            check("R3 request line", mem_req_line, V_LINE[i]);
            mem_req_ready = 1;
            cyc(); mem_req_ready = 0;
            refill_valid = 1; refill_line = V_LINE[i]; refill_data = PAT; #1;
            check("R3 request dropped", mem_req_valid, 0);
            check("R7 busy before writeback", q_busy1, 1);
            check("R5 no early writeback", wb_valid, 0);
            cyc(); refill_valid = 0; #1;
            check("R5 writeback valid", wb_valid, 1);
            check("R5 writeback reg", wb_rd, V_RD[i]);
            check("R5 writeback data", wb_data, V_EXP[i]);
            check("R7 clear in writeback cycle", q_busy1, 0);
            cyc(); #1;
            check("R6 single writeback", wb_valid, 0);
        end

        // Merge, ordering, pending-destination refusal, unrelated refill.
        do_reset();
        cyc();
        alloc_valid = 1; alloc_line = 26'h100; alloc_off = 4'd0; alloc_size = 2'd2; alloc_rd = 5'd1;
        cyc();
        alloc_line = 26'h100; alloc_off = 4'd4; alloc_size = 2'd2; alloc_rd = 5'd2; q_rs1 = 5'd1; #1;
        check("R3 first request line", mem_req_line, 26'h100);
        mem_req_ready = 1;
        cyc(); alloc_valid = 0; mem_req_ready = 0; alloc_rd = 5'd1; #1;
        check("R4 no second request", mem_req_valid, 0);
        check("R9 pending rd refused", alloc_ready, 0);
        alloc_rd = 5'd9; #1;
        check("R9 free rd accepted", alloc_ready, 1);
        refill_valid = 1; refill_line = 26'h200; refill_data = PAT;
        cyc(); refill_valid = 0; #1;
        check("R11 unrelated refill no writeback", wb_valid, 0);
        check("R11 pending stays busy", q_busy1, 1);
        check("R4 still no request", mem_req_valid, 0);
        refill_valid = 1; refill_line = 26'h100;
        cyc(); refill_valid = 0; q_rs2 = 5'd2; #1;
        check("R6 lowest slot first valid", wb_valid, 1);
        check("R6 lowest slot first reg", wb_rd, 5'd1);
        check("R5 merged first data", wb_data, 64'hC3C2_C1C0);
        check("R7 second still busy", q_busy2, 1);
        cyc(); #1;
        check("R6 second writeback reg", wb_rd, 5'd2);
        check("R4 merged load data", wb_data, 64'hC7C6_C5C4);
        cyc(); #1;
        check("R6 idle after drain", wb_valid, 0);

        // Full buffer, request order, slot reuse timing, same-cycle refill.
        do_reset();
        for (int k = 0; k < 4; k++) begin
            cyc();
            alloc_valid = 1; alloc_line = 26'h300 + 26'(k); alloc_off = 4'd0;
            alloc_size = 2'd0; alloc_rd = 5'(k + 1);
        end
        cyc(); alloc_line = 26'h3FF; alloc_rd = 5'd5; q_rs1 = 5'd5; q_rs2 = 5'd3; #1;
        check("R8 full refuses", alloc_ready, 0);
        check("R12 idle reg not busy", q_busy1, 0);
        check("R12 pending reg busy", q_busy2, 1);
        cyc(); alloc_valid = 0; #1;
        check("R8 refused load not taken", q_busy1, 0);
        check("R3 order slot 0", mem_req_line, 26'h300);
        mem_req_ready = 1;
        for (int k = 1; k < 4; k++) begin
            cyc(); #1;
            check("R3 order next slot", mem_req_line, 26'h300 + 26'(k));
        end
        cyc(); mem_req_ready = 0; #1;
        check("R3 all requests sent", mem_req_valid, 0);
        refill_valid = 1; refill_line = 26'h302; refill_data = PAT;
        cyc(); refill_valid = 0; #1;
        check("R5 slot 2 writeback reg", wb_rd, 5'd3);
        check("R5 slot 2 data", wb_data, 64'hC0);
        check("R8 slot held during writeback", alloc_ready, 0);
        cyc(); #1;
        check("R8 slot free after writeback", alloc_ready, 1);
        alloc_valid = 1; alloc_line = 26'h3AA; alloc_off = 4'd15; alloc_size = 2'd0;
        refill_valid = 1; refill_line = 26'h3AA;
        cyc(); alloc_valid = 0; refill_valid = 0; #1;
        check("R10 immediate writeback", wb_valid, 1);
        check("R10 reg", wb_rd, 5'd5);
        check("R10 data", wb_data, 64'hCF);
        check("R10 no request", mem_req_valid, 0);

        summary();
    end

endmodule